// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block is a hardware sequencer that pushes a configuration bitstream into a target programmable device over a passive serial link. A controller gives it a start pulse and the total number of bytes. The block then takes the bytes one at a time through a valid/ready handshake. On the device side it drives an active-low configuration request, a serial clock and a serial data line. It samples the device's active-low status line and its configuration-complete line.

After a start, the block holds the configuration request low for a fixed interval and checks that the device pulled its status line low. It then releases the request and waits a settling interval. After that it polls for the status line to be released, up to a bounded timeout. Each byte goes out least significant bit first, with the data line updated while the serial clock is low. After the last byte the block checks that the device reports completion. It then issues a fixed burst of extra serial clock pulses and reports success. Any failure aborts the run, returns the link to idle and reports a two-bit error code.

Times are set by parameters in clock cycles, derived from a clock frequency in MHz (`CLK_MHZ`). The configuration-request low time and the settling time are both 2·`CLK_MHZ` cycles. The status timeout is `TIMEOUT_US`·`CLK_MHZ` cycles, counted from the release of the request. One serial clock half-period is `HALF_DIV` system clocks. With `HALF_DIV` = 2 at 125 MHz, the serial clock runs at 31.25 MHz, below the 50 MHz limit.

Top module: `scl_loader`

## Requirements
- R1: After a start pulse taken while idle, `ncfg_o` goes low for exactly 2·`CLK_MHZ` cycles. During that time `dclk_o` and `byte_ready_o` stay low and `busy_o` is high.
- R2: If `nstatus_i` reads high in the last cycle of the low interval, the run aborts with `err_code_o` = 1.
- R3: `nstatus_i` is ignored for 2·`CLK_MHZ` cycles after `ncfg_o` rises; a high level during that time causes no error. If it is still low `TIMEOUT_US`·`CLK_MHZ` cycles after `ncfg_o` rises, `error_o` rises exactly that many cycles after the release, with `err_code_o` = 2.
- R4: Exactly `total_bytes_i` bytes are accepted. Each byte produces 8 rising edges of `dclk_o`, with bit 0 on `data0_o` at the first edge and bit 7 at the eighth.
- R5: `dclk_o` stays high for exactly `HALF_DIV` cycles per pulse and stays low for at least `HALF_DIV` cycles between rising edges. `data0_o` changes only while `dclk_o` is low.
- R6: If `confdone_i` is low after the last byte has been shifted, the run aborts with `err_code_o` = 3.
- R7: If `confdone_i` is high, `TRAIL_CLKS` (12 by default) further `dclk_o` pulses follow with `data0_o` low. Then `done_o` rises and `busy_o` falls.
- R8: `byte_ready_o` is high only while the block waits for the next byte. It is never high while `dclk_o` is high or while the block is idle, and one byte is taken per cycle with `byte_ready_o` and `byte_valid_i` both high.
- R9: On any abort, `dclk_o` and `data0_o` go low, `ncfg_o` goes high and `byte_ready_o` stays low. Offered bytes are then ignored until the next start.
- R10: A start pulse while `busy_o` is high has no effect on the run in progress.
- R11: `done_o` and `error_o` are never both high. Each stays high until the next accepted start, which clears both on the edge that starts the run.
- R12: With `total_bytes_i` = 0, no byte is requested. The block goes straight from the status release to the completion check and the trailing pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| total_bytes_i | input | LEN_W | Number of bytes in the bitstream, latched at start |
| byte_data_i | input | 8 | Bitstream byte offered upstream |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_ready_o | output | 1 | Block takes the offered byte this cycle |
| ncfg_o | output | 1 | Active-low configuration request to the device |
| dclk_o | output | 1 | Serial clock; device samples on the rising edge |
| data0_o | output | 1 | Serial data |
| nstatus_i | input | 1 | Active-low device status |
| confdone_i | input | 1 | Device reports configuration complete |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished successfully (sticky) |
| error_o | output | 1 | Last load aborted (sticky) |
| err_code_o | output | 2 | 0 none, 1 status not asserted, 2 status timeout, 3 completion missing |

## Verification
`ncfg_o` falls on the first edge after the start is sampled. `error_o` for a timeout is due exactly `TIMEOUT_US`·`CLK_MHZ` edges after `ncfg_o` rises. Every `dclk_o` level lasts a multiple of `HALF_DIV` edges. The bench therefore measures intervals rather than guessing absolute cycle numbers. A monitor on the falling clock edge counts low cycles of `ncfg_o`, timestamps the release and the error rise, and measures each `dclk_o` high and low run. It rebuilds each byte from `data0_o` at every rising `dclk_o`. Inputs are driven 1 ns after the rising edge, and handshakes follow the ready level seen then. Final flags are read once `done_o` or `error_o` has risen.

// File: rtl/scl_pkg.sv
// Shared types for the passive serial configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_pkg;

    // Sequencer states, one per phase of a load.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_LOW,
        ST_SETTLE,
        ST_WAIT_ST,
        ST_FETCH,
        ST_SHIFT,
        ST_CHECK,
        ST_TRAIL
    } scl_state_t;

    // Error codes reported on err_code_o.
    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_STATUS   = 2'd1,
        ERR_TIMEOUT  = 2'd2,
        ERR_CONFDONE = 2'd3
    } scl_err_t;

endpackage

// File: rtl/scl_interval.sv
// Down-counting interval timer shared by the reset handshake phases.
// A load writes N-1; zero_o is high in the Nth cycle after the load.
// Assumes: load_val_i fits in W bits; the counter holds at zero.
module scl_interval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load a new interval or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/scl_serializer.sv
// Serial clock and data generator. On load_i it sends pulses_i clock
// pulses. Bit 0 of byte_i goes first, then the higher bits, then zeros.
// Each pulse is low for HALF_DIV cycles with data set, then high for
// HALF_DIV cycles. finish_o pulses for one cycle after the last fall.
// Assumes: load_i only when idle, pulses_i >= 1, HALF_DIV >= 1.
module scl_serializer #(
    parameter int HALF_DIV = 2,
    parameter int PULSE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [7:0]         byte_i,
    input  logic [PULSE_W-1:0] pulses_i,
    input  logic               abort_i,
    output logic               dclk_o,
    output logic               data0_o,
    output logic               finish_o
);

    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(HALF_DIV - 1);

    logic               run_q;
    logic [6:0]         sh_q;
    logic [PULSE_W-1:0] left_q;
    logic [DIV_W-1:0]   div_q;

    // Step through low and high half-periods and advance one bit per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            sh_q     <= '0;
            left_q   <= '0;
            div_q    <= '0;
            dclk_o   <= 1'b0;
            data0_o  <= 1'b0;
            finish_o <= 1'b0;
        end else if (abort_i) begin
            run_q    <= 1'b0;
            dclk_o   <= 1'b0;
            data0_o  <= 1'b0;
            finish_o <= 1'b0;
        end else begin
            finish_o <= 1'b0;
            if (load_i) begin
                run_q   <= 1'b1;
                sh_q    <= byte_i[7:1];
                data0_o <= byte_i[0];
                left_q  <= pulses_i - PULSE_W'(1);
                div_q   <= DIV_MAX;
                dclk_o  <= 1'b0;
            end else if (run_q) begin
                if (div_q != '0) begin
                    div_q <= div_q - DIV_W'(1);
                end else if (!dclk_o) begin
                    dclk_o <= 1'b1;
                    div_q  <= DIV_MAX;
                end else begin
                    dclk_o <= 1'b0;
                    if (left_q == '0) begin
                        run_q    <= 1'b0;
                        finish_o <= 1'b1;
                    end else begin
                        left_q  <= left_q - PULSE_W'(1);
                        data0_o <= sh_q[0];
                        sh_q    <= {1'b0, sh_q[6:1]};
                        div_q   <= DIV_MAX;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/scl_sequencer.sv
// Load sequencer: reset handshake, byte fetch, completion check, trailing
// pulses, and the sticky done/error flags.
// Assumes: TMO_CYC > SETTLE_CYC, and all intervals fit in WAIT_W bits.
module scl_sequencer
    import scl_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int WAIT_W     = 24,
    parameter int PULSE_W    = 4,
    parameter int LOW_CYC    = 250,
    parameter int SETTLE_CYC = 250,
    parameter int TMO_CYC    = 1000,
    parameter int TRAIL_CLKS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   total_bytes_i,
    input  logic [7:0]         byte_data_i,
    input  logic               byte_valid_i,
    output logic               byte_ready_o,
    output logic               ncfg_o,
    input  logic               nstatus_i,
    input  logic               confdone_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o,
    output logic [1:0]         err_code_o,
    input  logic               int_zero_i,
    output logic               int_load_o,
    output logic [WAIT_W-1:0]  int_val_o,
    input  logic               ser_finish_i,
    output logic               ser_load_o,
    output logic [7:0]         ser_byte_o,
    output logic [PULSE_W-1:0] ser_pulses_o,
    output logic               ser_abort_o
);

    scl_state_t       state_q, state_d;
    logic [LEN_W-1:0] total_q, sent_q;
    logic             accept, set_done, set_err, begin_run;
    scl_err_t         err_d;

    assign begin_run    = (state_q == ST_IDLE) && start_i;
    assign byte_ready_o = (state_q == ST_FETCH);
    assign ncfg_o       = (state_q != ST_CFG_LOW);
    assign busy_o       = (state_q != ST_IDLE);

    // Next-state and command decode for one phase of the load.
    always_comb begin
        state_d      = state_q;
        int_load_o   = 1'b0;
        int_val_o    = '0;
        ser_load_o   = 1'b0;
        ser_byte_o   = 8'h00;
        ser_pulses_o = '0;
        ser_abort_o  = 1'b0;
        accept       = 1'b0;
        set_done     = 1'b0;
        set_err      = 1'b0;
        err_d        = ERR_NONE;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_CFG_LOW;
                    int_load_o = 1'b1;
                    int_val_o  = WAIT_W'(LOW_CYC - 1);
                end
            end
            ST_CFG_LOW: begin
                if (int_zero_i) begin
                    if (nstatus_i) begin
                        state_d     = ST_IDLE;
                        set_err     = 1'b1;
                        err_d       = ERR_STATUS;
                        ser_abort_o = 1'b1;
                    end else begin
                        state_d    = ST_SETTLE;
                        int_load_o = 1'b1;
                        int_val_o  = WAIT_W'(SETTLE_CYC - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (int_zero_i) begin
                    state_d    = ST_WAIT_ST;
                    int_load_o = 1'b1;
                    int_val_o  = WAIT_W'(TMO_CYC - SETTLE_CYC - 1);
                end
            end
            ST_WAIT_ST: begin
                if (nstatus_i) begin
                    state_d = (total_q == '0) ? ST_CHECK : ST_FETCH;
                end else if (int_zero_i) begin
                    state_d     = ST_IDLE;
                    set_err     = 1'b1;
                    err_d       = ERR_TIMEOUT;
                    ser_abort_o = 1'b1;
                end
            end
            ST_FETCH: begin
                if (byte_valid_i) begin
                    accept       = 1'b1;
                    ser_load_o   = 1'b1;
                    ser_byte_o   = byte_data_i;
                    ser_pulses_o = PULSE_W'(8);
                    state_d      = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (ser_finish_i) begin
                    state_d = (sent_q == total_q) ? ST_CHECK : ST_FETCH;
                end
            end
            ST_CHECK: begin
                if (confdone_i) begin
                    ser_load_o   = 1'b1;
                    ser_pulses_o = PULSE_W'(TRAIL_CLKS);
                    state_d      = ST_TRAIL;
                end else begin
                    state_d     = ST_IDLE;
                    set_err     = 1'b1;
                    err_d       = ERR_CONFDONE;
                    ser_abort_o = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (ser_finish_i) begin
                    state_d  = ST_IDLE;
                    set_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, byte bookkeeping and sticky result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            total_q    <= '0;
            sent_q     <= '0;
            done_o     <= 1'b0;
            error_o    <= 1'b0;
            err_code_o <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (begin_run) begin
                total_q    <= total_bytes_i;
                sent_q     <= '0;
                done_o     <= 1'b0;
                error_o    <= 1'b0;
                err_code_o <= ERR_NONE;
            end
            if (accept) begin
                sent_q <= sent_q + LEN_W'(1);
            end
            if (set_done) begin
                done_o <= 1'b1;
            end
            if (set_err) begin
                error_o    <= 1'b1;
                err_code_o <= err_d;
            end
        end
    end

endmodule

// File: rtl/scl_loader.sv
// Top of the passive serial configuration loader. Derives all cycle counts
// from the clock frequency in MHz and wires the sequencer, interval timer
// and serializer together.
// Assumes: TIMEOUT_US*CLK_MHZ > 2*CLK_MHZ; HALF_DIV keeps the serial clock
// at or below 50 MHz.
module scl_loader #(
    parameter int CLK_MHZ    = 125,
    parameter int TIMEOUT_US = 100000,
    parameter int HALF_DIV   = 2,
    parameter int TRAIL_CLKS = 12,
    parameter int LEN_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] total_bytes_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             ncfg_o,
    output logic             dclk_o,
    output logic             data0_o,
    input  logic             nstatus_i,
    input  logic             confdone_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o,
    output logic [1:0]       err_code_o
);

    localparam int LOW_CYC    = 2 * CLK_MHZ;
    localparam int SETTLE_CYC = 2 * CLK_MHZ;
    localparam int TMO_CYC    = TIMEOUT_US * CLK_MHZ;
    localparam int WAIT_W     = $clog2(TMO_CYC + 1);
    localparam int MAX_PULSES = (TRAIL_CLKS > 8) ? TRAIL_CLKS : 8;
    localparam int PULSE_W    = $clog2(MAX_PULSES + 1);

    logic              int_zero, int_load;
    logic [WAIT_W-1:0] int_val;
    logic              ser_finish, ser_load, ser_abort;
    logic [7:0]        ser_byte;
    logic [PULSE_W-1:0] ser_pulses;

    scl_sequencer #(
        .LEN_W      (LEN_W),
        .WAIT_W     (WAIT_W),
        .PULSE_W    (PULSE_W),
        .LOW_CYC    (LOW_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .TMO_CYC    (TMO_CYC),
        .TRAIL_CLKS (TRAIL_CLKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .total_bytes_i (total_bytes_i),
        .byte_data_i   (byte_data_i),
        .byte_valid_i  (byte_valid_i),
        .byte_ready_o  (byte_ready_o),
        .ncfg_o        (ncfg_o),
        .nstatus_i     (nstatus_i),
        .confdone_i    (confdone_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .error_o       (error_o),
        .err_code_o    (err_code_o),
        .int_zero_i    (int_zero),
        .int_load_o    (int_load),
        .int_val_o     (int_val),
        .ser_finish_i  (ser_finish),
        .ser_load_o    (ser_load),
        .ser_byte_o    (ser_byte),
        .ser_pulses_o  (ser_pulses),
        .ser_abort_o   (ser_abort)
    );

    scl_interval #(
        .W (WAIT_W)
    ) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (int_load),
        .load_val_i (int_val),
        .zero_o     (int_zero)
    );

    scl_serializer #(
        .HALF_DIV (HALF_DIV),
        .PULSE_W  (PULSE_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ser_load),
        .byte_i   (ser_byte),
        .pulses_i (ser_pulses),
        .abort_i  (ser_abort),
        .dclk_o   (dclk_o),
        .data0_o  (data0_o),
        .finish_o (ser_finish)
    );

endmodule

// File: rtl/scl_loader_chk.sv
// Protocol checker for the loader's ports, bound to every scl_loader.
// Assumes: synchronous active-low reset on rst_n.
module scl_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_ready_o,
    input logic       ncfg_o,
    input logic       dclk_o,
    input logic       data0_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       error_o,
    input logic [1:0] err_code_o
);

    // R1: configuration request low only inside a run, with the link quiet
    assert_ncfg_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> (busy_o && !dclk_o && !byte_ready_o));

    // R5: serial data never moves while the serial clock is high
    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> $stable(data0_o));

    // R8: a byte is requested only during a run and with the clock low
    assert_ready_low_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && !dclk_o));

    // R9: after an abort the link sits idle
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (ncfg_o && !dclk_o && !data0_o && !byte_ready_o));

    // R2: an error always carries a non-zero code
    assert_err_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (err_code_o != 2'd0));

    // R11: success and failure never reported together
    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    // R11: done clears only when a new run begins
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> busy_o);

    // R11: error clears only when a new run begins
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error_o) |-> busy_o);

    // R7: success is reported as the run ends
    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o);

endmodule

bind scl_loader scl_loader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_ready_o (byte_ready_o),
    .ncfg_o       (ncfg_o),
    .dclk_o       (dclk_o),
    .data0_o      (data0_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .err_code_o   (err_code_o)
);

// File: tb/scl_loader_bench.sv
`timescale 1ns/1ps
module scl_loader_bench;

    localparam int MHZ   = 4;
    localparam int TUS   = 10;
    localparam int HALF  = 2;
    localparam int TRAIL = 12;
    localparam int LOW_EXP = 2 * MHZ;
    localparam int TMO_EXP = TUS * MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [15:0] total_bytes_i = '0;
    logic [7:0] byte_data_i = '0;
    logic byte_valid_i = 1'b0;
    logic byte_ready_o, ncfg_o, dclk_o, data0_o;
    logic nstatus_i = 1'b1;
    logic confdone_i = 1'b1;
    logic busy_o, done_o, error_o;
    logic [1:0] err_code_o;

    always #4 clk = ~clk;

    scl_loader #(
        .CLK_MHZ(MHZ), .TIMEOUT_US(TUS), .HALF_DIV(HALF),
        .TRAIL_CLKS(TRAIL), .LEN_W(16)
    ) u_scl_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .total_bytes_i(total_bytes_i), .byte_data_i(byte_data_i),
        .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .ncfg_o(ncfg_o), .dclk_o(dclk_o), .data0_o(data0_o),
        .nstatus_i(nstatus_i), .confdone_i(confdone_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .err_code_o(err_code_o)
    );

    int checks = 0;
    int errors = 0;

    // Device status model: 0 normal release after rel_delay, 1 stuck high, 2 stuck low.
    int st_mode = 0;
    int rel_delay = 3;
    int rcnt = 0;
    always @(negedge clk) begin
        case (st_mode)
            0: begin
                if (!ncfg_o) begin nstatus_i <= 1'b0; rcnt <= 0; end
                else if (!nstatus_i) begin
                    if (rcnt >= rel_delay) nstatus_i <= 1'b1;
                    else rcnt <= rcnt + 1;
                end
            end
            1: nstatus_i <= 1'b1;
            default: if (!ncfg_o) nstatus_i <= 1'b0;
        endcase
    end

    // Port monitor on the falling edge.
    logic mon_clr = 1'b0;
    int exp_n = 0;
    int cyc = 0, low_cnt = 0, rises = 0, tr_bad = 0, wid_bad = 0, rdy_bad = 0;
    int hi_len = 0, lo_len = 0, rel_stamp = 0, err_stamp = 0;
    logic seen_fall = 1'b0, p_dclk = 1'b0, p_data = 1'b0, p_ncfg = 1'b1, p_err = 1'b0;
    logic [7:0] rx [0:255];
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            low_cnt = 0; rises = 0; tr_bad = 0; wid_bad = 0; rdy_bad = 0;
            hi_len = 0; lo_len = 0; seen_fall = 1'b0;
        end else begin
            if (!ncfg_o) low_cnt++;
            if (ncfg_o && !p_ncfg) rel_stamp = cyc;
            if (error_o && !p_err) err_stamp = cyc;
            if (dclk_o && !p_dclk) begin
                if (seen_fall && lo_len < HALF) wid_bad++;
                if (rises < exp_n * 8) rx[rises / 8][rises % 8] = data0_o;
                else if (data0_o) tr_bad++;
                rises++;
                hi_len = 0;
            end
            if (!dclk_o && p_dclk) begin
                if (hi_len != HALF) wid_bad++;
                seen_fall = 1'b1;
                lo_len = 0;
            end
            if (dclk_o && p_dclk && data0_o != p_data) wid_bad++;
            if (dclk_o) hi_len++; else lo_len++;
            if (byte_ready_o && (dclk_o || !busy_o)) rdy_bad++;
        end
        p_dclk = dclk_o; p_data = data0_o; p_ncfg = ncfg_o; p_err = error_o;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic begin_load(input int n);
        exp_n = n;
        total_bytes_i = 16'(n);
        step(); mon_clr = 1'b1;
        step(); mon_clr = 1'b0; start_i = 1'b1;
        step(); start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) step();
        byte_valid_i = 1'b1;
        byte_data_i = b;
        while (!byte_ready_o) step();
        step();
        byte_valid_i = 1'b0;
    endtask

    task automatic wait_end();
        int guard = 0;
        while (!(done_o || error_o) && guard < 30000) begin step(); guard++; end
        step(); step();
    endtask

    task automatic hold_valid_idle(input string tag);
        int bad = 0;
        int r0 = rises;
        byte_valid_i = 1'b1;
        for (int k = 0; k < 30; k++) begin
            step();
            if (byte_ready_o || dclk_o || data0_o || !ncfg_o) bad++;
        end
        byte_valid_i = 1'b0;
        chk(bad == 0 && rises == r0, tag, bad, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // Reset state
        chk(ncfg_o && !dclk_o && !data0_o && !byte_ready_o && !busy_o &&
            !done_o && !error_o && err_code_o == 2'd0, "reset state R8", 0, 0);

        // Normal four-byte load, fast status release
        st_mode = 0; rel_delay = 3; confdone_i = 1'b1;
        begin_load(4);
        chk(busy_o && !ncfg_o && !done_o && !error_o, "start clears flags R11", busy_o, 1);
        send_byte(8'hA5, 0); send_byte(8'h3C, 0); send_byte(8'h01, 1); send_byte(8'h80, 0);
        wait_end();
        chk(low_cnt == LOW_EXP, "ncfg low length R1", low_cnt, LOW_EXP);
        chk(done_o && !error_o && !busy_o, "done after settle-time release R3", done_o, 1);
        chk(rx[0] == 8'hA5 && rx[1] == 8'h3C && rx[2] == 8'h01 && rx[3] == 8'h80,
            "LSB-first bytes R4", int'(rx[0]), 'hA5);
        chk(rises == 4 * 8 + TRAIL, "pulse count incl trailing R7", rises, 4 * 8 + TRAIL);
        chk(tr_bad == 0, "trailing data low R7", tr_bad, 0);
        chk(wid_bad == 0, "dclk widths and data stability R5", wid_bad, 0);
        chk(rdy_bad == 0, "ready only while fetching R8", rdy_bad, 0);
        repeat (40) step();
        chk(done_o && !error_o, "done sticky R11", done_o, 1);

        // Exhaustive byte sweep, late status release, stray start mid-load
        rel_delay = 20;
        begin_load(256);
        for (int i = 0; i < 256; i++) begin
            if (i == 100) begin start_i = 1'b1; step(); start_i = 1'b0; end
            send_byte(8'(i), i % 3);
        end
        wait_end();
        begin
            int miss = 0;
            for (int i = 0; i < 256; i++) if (rx[i] != 8'(i)) miss++;
            chk(miss == 0, "all 256 byte values R4", miss, 0);
        end
        chk(done_o && !error_o, "late status release succeeds R3", done_o, 1);
        chk(low_cnt == LOW_EXP, "start while busy ignored R10", low_cnt, LOW_EXP);
        chk(rises == 256 * 8 + TRAIL, "sweep pulse count R10", rises, 256 * 8 + TRAIL);
        chk(wid_bad == 0 && rdy_bad == 0, "sweep timing R5 R8", wid_bad + rdy_bad, 0);

        // Status never pulled low
        st_mode = 1;
        begin_load(2);
        wait_end();
        chk(error_o && err_code_o == 2'd1, "status not asserted R2", int'(err_code_o), 1);
        chk(low_cnt == LOW_EXP && rises == 0, "no clocks after status error R2", rises, 0);
        hold_valid_idle("bytes ignored after abort R9");

        // Status never released
        st_mode = 2;
        begin_load(2);
        wait_end();
        chk(error_o && err_code_o == 2'd2, "timeout code R3", int'(err_code_o), 2);
        chk(err_stamp - rel_stamp == TMO_EXP, "timeout interval R3", err_stamp - rel_stamp, TMO_EXP);

        // Completion line stays low
        st_mode = 0; rel_delay = 3; confdone_i = 1'b0;
        begin_load(2);
        send_byte(8'hF0, 0); send_byte(8'h0F, 2);
        wait_end();
        chk(error_o && err_code_o == 2'd3 && !done_o, "completion missing R6", int'(err_code_o), 3);
        chk(rises == 16 && rx[0] == 8'hF0 && rx[1] == 8'h0F, "bytes sent before check R6", rises, 16);
        hold_valid_idle("link idle after completion error R9");
        chk(error_o, "error sticky R11", error_o, 1);

        // Zero-length load
        confdone_i = 1'b1;
        begin_load(0);
        chk(!error_o && !done_o && busy_o, "start clears error R11", error_o, 0);
        wait_end();
        chk(done_o && rises == TRAIL && rdy_bad == 0, "zero-length load R12", rises, TRAIL);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

endmodule